// File: doc/BRIEF.md
# Ripple-Carry Twelve-Hour Binary Time Counter

This block keeps the time of day on a twelve-hour dial. It steps once for every cycle in which its one-second `tick` input is high. The time is held as five 4-bit fields and one AM/PM flag. The five fields are seconds units, seconds tens, minutes units, minutes tens and a plain binary hour from 0 to 11, where 0 stands for twelve o'clock. Only the seconds units field counts on the tick itself. Every other field steps when one chosen bit of the field below it goes from 1 to 0. The old value of that bit comes from a register that is rewritten on every tick, so a carry can ripple through every stage within a single tick.

A synchronous preset port loads a full 24-hour time in one cycle. Hours of 12 and above are stored as the hour minus twelve, with the PM flag set. The outputs are the 20 time bits as one packed vector plus the flag. Turning the time into characters for a display, and producing the one-second tick, are left to the surrounding logic.

Top module: `edge_carry_clock`

## Requirements
- R1: While `rstN` is low, every time field is 0 and `pmFlag` is 0 (AM); both stay there until the first tick or load after reset.
- R2: The seconds units field advances by one on every tick and goes from 9 back to 0; it never exceeds 9.
- R3: The seconds tens and minutes tens fields count 0 to 5 and wrap to 0; their most significant bit (`timeBits[7]` and `timeBits[15]`) is always 0.
- R4: Seconds tens advances in exactly the tick where the weight-8 bit of seconds units falls, that is when seconds units goes from 9 to 0; otherwise it holds.
- R5: Minutes units (0 to 9, wrapping) advances in exactly the tick where the weight-4 bit of seconds tens falls, that is on its change from 5 to 0.
- R6: Minutes tens advances in exactly the tick where the weight-8 bit of minutes units falls, that is on its change from 9 to 0.
- R7: The hour field is a plain binary count from 0 to 11 that wraps to 0. It advances when the weight-4 bit of minutes tens falls, that is on its change from 5 to 0.
- R8: `pmFlag` (1 = PM, 0 = AM) inverts in exactly the tick where the weight-8 bit of the hour falls, which is the change from 11 to 0.
- R9: In a cycle with neither `tick` nor `loadEn` high, every output keeps its value.
- R10: When `loadEn` is high, the next cycle shows the loaded minutes and seconds fields. A `loadHour` of 12 to 23 is stored as `loadHour`-12 with `pmFlag`=1, and a value of 0 to 11 is stored unchanged with `pmFlag`=0. A load in the same cycle as a tick wins over the tick.
- R11: A load also sets the stored old value of every carry bit from the loaded fields. The first tick after a load therefore makes no carry that the loaded time does not call for.
- R12: `timeBits` is ordered hour [19:16], minutes tens [15:12], minutes units [11:8], seconds tens [7:4], seconds units [3:0], with each field written most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second advance strobe |
| loadEn | input | 1 | Preset strobe, takes priority over `tick` |
| loadHour | input | 5 | Preset hour on a 24-hour scale, 0 to 23 |
| loadMinTens | input | 4 | Preset minutes tens, 0 to 5 |
| loadMinUnits | input | 4 | Preset minutes units, 0 to 9 |
| loadSecTens | input | 4 | Preset seconds tens, 0 to 5 |
| loadSecUnits | input | 4 | Preset seconds units, 0 to 9 |
| timeBits | output | 20 | Packed time, hour down to seconds units |
| pmFlag | output | 1 | 1 = PM, 0 = AM |

## Verification
The hardest state to reach from the ports is a full ripple, where one tick carries through every stage and flips the AM/PM flag. Without presets it needs 43,200 ticks. The table-driven stimulus loads times such as 11:59:59 and 23:59:59, so that each carry boundary is one tick away. A full day of ticks then confirms that the flag comes back after two wraps. A second case is hard to reach because the old copy of a carry bit cannot be seen at the ports. The stimulus first drives seconds units to 9 by ticking, then loads a time whose weight-8 bit is 0, and checks that the next tick does not step seconds tens.

// File: rtl/edge_carry_clock_pkg.sv
package edge_carry_clock_pkg;

  localparam int NUM_STAGES = 5;
  localparam int DIGIT_W    = 4;
  localparam int HOUR_IN_W  = 5;
  localparam int TIME_W     = NUM_STAGES * DIGIT_W;
  localparam int HALF_DAY   = 12;

  // Stage index: 0 sec units, 1 sec tens, 2 min units, 3 min tens, 4 hour
  typedef logic [NUM_STAGES-1:0][DIGIT_W-1:0] digitVec_t;

  typedef struct packed {
    logic                  load;
    logic [NUM_STAGES-1:0] advance;
    logic                  pmFlip;
  } stageStrobes_t;

  function automatic int stageModulus(input int idx);
    case (idx)
      0, 2:    return 10;
      1, 3:    return 6;
      default: return HALF_DAY;
    endcase
  endfunction

  // Bit of stage idx whose falling edge advances stage idx+1 (or the flag)
  function automatic int carryBit(input int idx);
    case (idx)
      1, 3:    return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/digit_stage.sv
module digit_stage #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             load,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] incValue
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  always_comb begin
    if (value >= LAST) incValue = '0;
    else               incValue = value + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        value <= '0;
    else if (load)    value <= loadValue;
    else if (advance) value <= incValue;
  end

endmodule

// File: rtl/edge_carry_datapath.sv
module edge_carry_datapath
  import edge_carry_clock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  stageStrobes_t        strobes,
  input  logic [HOUR_IN_W-1:0] loadHour,
  input  logic [DIGIT_W-1:0]   loadMinTens,
  input  logic [DIGIT_W-1:0]   loadMinUnits,
  input  logic [DIGIT_W-1:0]   loadSecTens,
  input  logic [DIGIT_W-1:0]   loadSecUnits,
  output digitVec_t            curDigits,
  output digitVec_t            incDigits,
  output digitVec_t            loadDigits,
  output logic                 pmState
);

  localparam logic [HOUR_IN_W-1:0] HALF = HOUR_IN_W'(HALF_DAY);

  logic                 loadPm;
  logic [HOUR_IN_W-1:0] hourAdj;

  always_comb begin
    loadPm  = (loadHour >= HALF);
    hourAdj = loadPm ? (loadHour - HALF) : loadHour;
    loadDigits[0] = loadSecUnits;
    loadDigits[1] = loadSecTens;
    loadDigits[2] = loadMinUnits;
    loadDigits[3] = loadMinTens;
    loadDigits[4] = hourAdj[DIGIT_W-1:0];
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    digit_stage #(
      .WIDTH  (DIGIT_W),
      .MODULUS(stageModulus(g))
    ) u_digit (
      .clk      (clk),
      .rstN     (rstN),
      .advance  (strobes.advance[g]),
      .load     (strobes.load),
      .loadValue(loadDigits[g]),
      .value    (curDigits[g]),
      .incValue (incDigits[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pmState <= 1'b0;
    else if (strobes.load)   pmState <= loadPm;
    else if (strobes.pmFlip) pmState <= ~pmState;
  end

endmodule

// File: rtl/edge_carry_control.sv
module edge_carry_control
  import edge_carry_clock_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          loadEn,
  input  digitVec_t     curDigits,
  input  digitVec_t     incDigits,
  input  digitVec_t     loadDigits,
  output stageStrobes_t strobes
);

  logic [NUM_STAGES-1:0] prevBit;
  logic [NUM_STAGES-1:0] newBit;
  logic [NUM_STAGES-1:0] loadBit;
  logic [NUM_STAGES-1:0] advance;
  logic                  pmFlip;

  // Ripple: each stage's drive bit after this tick is compared with the
  // copy held from the previous tick; a 1-to-0 change enables the next stage.
  always_comb begin
    logic carry;
    carry = tick & ~loadEn;
    for (int i = 0; i < NUM_STAGES; i++) begin
      advance[i] = carry;
      newBit[i]  = carry ? incDigits[i][carryBit(i)] : curDigits[i][carryBit(i)];
      loadBit[i] = loadDigits[i][carryBit(i)];
      carry      = carry & prevBit[i] & ~newBit[i];
    end
    pmFlip = carry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevBit <= '0;
    else if (loadEn) prevBit <= loadBit;
    else if (tick)   prevBit <= newBit;
  end

  always_comb begin
    strobes.load    = loadEn;
    strobes.advance = advance;
    strobes.pmFlip  = pmFlip;
  end

endmodule

// File: rtl/edge_carry_clock.sv
module edge_carry_clock
  import edge_carry_clock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 loadEn,
  input  logic [HOUR_IN_W-1:0] loadHour,
  input  logic [DIGIT_W-1:0]   loadMinTens,
  input  logic [DIGIT_W-1:0]   loadMinUnits,
  input  logic [DIGIT_W-1:0]   loadSecTens,
  input  logic [DIGIT_W-1:0]   loadSecUnits,
  output logic [TIME_W-1:0]    timeBits,
  output logic                 pmFlag
);

  stageStrobes_t strobes;
  digitVec_t     curDigits;
  digitVec_t     incDigits;
  digitVec_t     loadDigits;

  edge_carry_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .loadEn    (loadEn),
    .curDigits (curDigits),
    .incDigits (incDigits),
    .loadDigits(loadDigits),
    .strobes   (strobes)
  );

  edge_carry_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .loadHour    (loadHour),
    .loadMinTens (loadMinTens),
    .loadMinUnits(loadMinUnits),
    .loadSecTens (loadSecTens),
    .loadSecUnits(loadSecUnits),
    .curDigits   (curDigits),
    .incDigits   (incDigits),
    .loadDigits  (loadDigits),
    .pmState     (pmFlag)
  );

  // Stage 4 (hour) lands in the top nibble, stage 0 in the bottom one
  assign timeBits = curDigits;

endmodule

// File: rtl/edge_carry_clock_chk.sv
module edge_carry_clock_chk
  import edge_carry_clock_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 loadEn,
  input logic [HOUR_IN_W-1:0] loadHour,
  input logic [DIGIT_W-1:0]   loadMinTens,
  input logic [DIGIT_W-1:0]   loadMinUnits,
  input logic [DIGIT_W-1:0]   loadSecTens,
  input logic [DIGIT_W-1:0]   loadSecUnits,
  input logic [TIME_W-1:0]    timeBits,
  input logic                 pmFlag
);

  logic [3:0] su, st, hr;
  assign su = timeBits[3:0];
  assign st = timeBits[7:4];
  assign hr = timeBits[19:16];

  logic stepping;
  assign stepping = tick & ~loadEn;

  assert_units_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    su <= 4'd9);

  assert_units_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    stepping |=> su == (($past(su) == 4'd9) ? 4'd0 : $past(su) + 4'd1));

  assert_tens_msb_R3: assert property (@(posedge clk) disable iff (!rstN)
    !timeBits[15] && !timeBits[7]);

  assert_sec_tens_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && su != 4'd9) |=> $stable(st));

  assert_hour_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    hr <= 4'd11);

  assert_pm_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && timeBits == 20'hB5959) |=> (pmFlag != $past(pmFlag)) && timeBits == 20'h0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadEn) |=> $stable(timeBits) && $stable(pmFlag));

  assert_load_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> timeBits[15:0] == $past({loadMinTens, loadMinUnits, loadSecTens, loadSecUnits}));

  assert_load_pm_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> pmFlag == ($past(loadHour) >= 5'd12));

endmodule

bind edge_carry_clock edge_carry_clock_chk u_chk (.*);

// File: tb/edge_carry_clock_tb.sv
module edge_carry_clock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam int NUM_VEC = 12;

  // {loadHour(5), minTens, minUnits, secTens, secUnits, ticks(8), expPm, expBits(20)}
  localparam logic [49:0] VECS [NUM_VEC] = '{
    {5'd0,  16'h0000, 8'd1,   1'b0, 20'h00001},  // R2
    {5'd0,  16'h0009, 8'd1,   1'b0, 20'h00010},  // R4
    {5'd0,  16'h0059, 8'd1,   1'b0, 20'h00100},  // R5
    {5'd0,  16'h0959, 8'd1,   1'b0, 20'h01000},  // R6
    {5'd0,  16'h5959, 8'd1,   1'b0, 20'h10000},  // R7
    {5'd11, 16'h5959, 8'd1,   1'b1, 20'h00000},  // R8 AM->PM
    {5'd23, 16'h5959, 8'd1,   1'b0, 20'h00000},  // R8 PM->AM
    {5'd13, 16'h4527, 8'd0,   1'b1, 20'h14527},  // R10 R12
    {5'd12, 16'h0000, 8'd0,   1'b1, 20'h00000},  // R10
    {5'd3,  16'h1450, 8'd15,  1'b0, 20'h31505},  // R5
    {5'd10, 16'h5958, 8'd3,   1'b0, 20'hB0001},  // R7
    {5'd0,  16'h0000, 8'd125, 1'b0, 20'h00205}   // R2 R4 R5
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        loadEn = 1'b0;
  logic [4:0]  loadHour = '0;
  logic [3:0]  loadMinTens = '0, loadMinUnits = '0, loadSecTens = '0, loadSecUnits = '0;
  logic [19:0] timeBits;
  logic        pmFlag;

  int checks = 0;
  int failures = 0;
  int badRange = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_carry_clock u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .loadEn(loadEn),
    .loadHour(loadHour), .loadMinTens(loadMinTens), .loadMinUnits(loadMinUnits),
    .loadSecTens(loadSecTens), .loadSecUnits(loadSecUnits),
    .timeBits(timeBits), .pmFlag(pmFlag)
  );

  always @(negedge clk) begin
    if (monOn && (timeBits[15] || timeBits[7] || timeBits[3:0] > 4'd9 ||
                  timeBits[11:8] > 4'd9 || timeBits[19:16] > 4'd11))
      badRange++;
  end

  task automatic checkTime(input string req, input logic expPm, input logic [19:0] expBits);
    checks++;
    if (pmFlag !== expPm || timeBits !== expBits) begin
      failures++;
      $display("FAIL %s: actual pm=%0b time=%05h expected pm=%0b time=%05h",
               req, pmFlag, timeBits, expPm, expBits);
    end
  endtask

  task automatic doLoad(input logic [4:0] h, input logic [15:0] mmss, input logic withTick);
    loadHour = h;
    {loadMinTens, loadMinUnits, loadSecTens, loadSecUnits} = mmss;
    loadEn = 1'b1;
    tick = withTick;
    @(negedge clk);
    loadEn = 1'b0;
    tick = 1'b0;
  endtask

  task automatic runTicks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual cycles=%0d expected fewer", WATCHDOG_CYCLES);
    finishRun();
  end

  initial begin
    // R1: reset state, ticks ignored while in reset
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    checkTime("R1 reset", 1'b0, 20'h00000);
    rstN = 1'b1;
    @(negedge clk);
    checkTime("R1 after release", 1'b0, 20'h00000);

    for (int i = 0; i < NUM_VEC; i++) begin
      doLoad(VECS[i][49:45], VECS[i][44:29], 1'b0);
      runTicks(int'(VECS[i][28:21]));
      checkTime($sformatf("R2-R8,R10,R12 vector %0d", i), VECS[i][20], VECS[i][19:0]);
    end

    // R9: no tick, no load -> hold
    doLoad(5'd21, 16'h3742, 1'b0);
    repeat (6) @(negedge clk);
    checkTime("R9 hold", 1'b1, 20'h93742);

    // R10: load wins over a tick in the same cycle
    doLoad(5'd7, 16'h1208, 1'b1);
    checkTime("R10 load priority", 1'b0, 20'h71208);

    // R11: drive seconds units to 9 (weight-8 bit high), then load 0
    doLoad(5'd0, 16'h0008, 1'b0);
    runTicks(1);
    checkTime("R11 setup", 1'b0, 20'h00009);
    doLoad(5'd0, 16'h0000, 1'b0);
    runTicks(1);
    checkTime("R11 no false carry", 1'b0, 20'h00001);

    // R11: minutes-tens weight-4 bit high before load, cleared by load
    doLoad(5'd2, 16'h5000, 1'b0);
    doLoad(5'd2, 16'h0000, 1'b0);
    runTicks(1);
    checkTime("R11 no false hour carry", 1'b0, 20'h20001);

    // R7 R8 R3: one full day of ticks from midnight
    doLoad(5'd0, 16'h0000, 1'b0);
    monOn = 1'b1;
    runTicks(43200);
    checkTime("R8 half day", 1'b1, 20'h00000);
    runTicks(43200);
    checkTime("R8 full day", 1'b0, 20'h00000);
    monOn = 1'b0;
    checks++;
    if (badRange != 0) begin
      failures++;
      $display("FAIL R3 field range: actual bad=%0d expected 0", badRange);
    end

    finishRun();
  end

endmodule